// File: doc/BRIEF.md
# Battery Gauge Status Flag Register

This block holds the eight-bit status word of a battery fuel gauge. On each valid measurement sample it re-evaluates the flags that describe the present operating point: current direction, idle current, charge taper and the two end-of-discharge levels. It compares the signed average current, the battery voltage code and the remaining capacity against programmable thresholds. It also tracks a capacity learning cycle. A qualify strobe marks a discharge as valid for learning, and a disqualify strobe cancels it. A flag that says the capacity figure is not trusted is set by a full reset and is cleared only when a learning cycle ends in a capacity update.

When the first end-of-discharge flag goes from 0 to 1 while a learning discharge is qualified, the block issues a one-cycle learned-capacity update pulse to the capacity logic. In the same step it closes the learning cycle. The host sees the register through a read-only port, and any write it attempts is discarded.

Top module: `gauge_flag_reg`

## Requirements
- R1: After `rst_n` is deasserted, and one cycle after a `fullResetReq`, `statusFlags` equals 8'h10: only bit 4 (capacity-inaccurate) is set.
- R2: One cycle after a `partialResetReq` (with no full reset), every bit is 0 except bit 4, which keeps its previous value.
- R3: One cycle after `sampleValid`, bit 7 (charge-state) is 1 exactly when `avgCurrent` (two's complement, positive means charge) is greater than zero.
- R4: One cycle after `sampleValid`, bit 6 (no-activity) is 1 exactly when |`avgCurrent`| < `idleThresh`. The magnitude of the most negative code is exact.
- R5: One cycle after `sampleValid`, bit 5 (taper) is 1 exactly when the current is charging, `avgCurrent` < `taperThresh`, and `battVolt` >= `taperVolt`.
- R6: One cycle after `sampleValid`, bit 1 (end-of-discharge-1) is 1 exactly when the current is not charging, `battVolt` <= `edv1Volt`, and `remCap` <= `learnedCap` >> 4. A charging sample clears it.
- R7: One cycle after `sampleValid`, bit 0 (end-of-discharge-final) is 1 exactly when the current is not charging and `remCap` <= `emptyCap`. A charging sample clears it.
- R8: Without `sampleValid`, bits 7, 6, 5, 1 and 0 hold their values, even when the measurement inputs change.
- R9: Bit 2 (valid-discharge) is set one cycle after `qualifyStrobe`. It is cleared one cycle after `disqualifyStrobe`, and the disqualify wins if both strobes arrive together.
- R10: `capUpdate` is high for exactly one cycle, in the same cycle that bit 1 first shows 1, when that sample raised bit 1 from 0 while bit 2 was set. With that pulse, bits 2 and 4 read 0.
- R11: Bit 4 is cleared only by the update of R10. A disqualify, a partial reset or an end-of-discharge-1 rise with bit 2 clear leaves it unchanged.
- R12: Bit 3 is reserved and always reads 0.
- R13: When `hostRdEn` is high, `hostRdData` shows that cycle's `statusFlags` one cycle later. `hostWrEn` and `hostWrData` never change `statusFlags`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, acts as a full reset |
| sampleValid | input | 1 | Measurement inputs are valid this cycle |
| avgCurrent | input | CUR_W | Signed average current, positive = charge |
| battVolt | input | VOLT_W | Battery voltage code |
| remCap | input | CAP_W | Remaining capacity |
| learnedCap | input | CAP_W | Learned maximum capacity |
| idleThresh | input | CUR_W | Idle-current magnitude threshold |
| taperThresh | input | CUR_W | Taper current threshold |
| taperVolt | input | VOLT_W | Minimum voltage for taper detection |
| edv1Volt | input | VOLT_W | End-of-discharge-1 voltage threshold |
| emptyCap | input | CAP_W | Capacity at or below which the battery is empty |
| qualifyStrobe | input | 1 | Learning discharge has qualified |
| disqualifyStrobe | input | 1 | Learning discharge has been disqualified |
| fullResetReq | input | 1 | Full flag reset request |
| partialResetReq | input | 1 | Partial flag reset request, bit 4 kept |
| hostRdEn | input | 1 | Host read request |
| hostWrEn | input | 1 | Host write attempt, ignored |
| hostWrData | input | 8 | Host write data, ignored |
| statusFlags | output | 8 | Current flag register |
| hostRdData | output | 8 | Registered host read data |
| capUpdate | output | 1 | One-cycle learned-capacity update pulse |

## Verification
Every flag, the update pulse and the read data are due one clock edge after the strobe that causes them, because each passes through a single register. The bench drives inputs on the falling edge and compares on the next falling edge, after exactly one rising edge. It then checks the cycle after that again to confirm that `capUpdate` fell and that the held bits stayed put. A reference model in the bench tracks the learning state from the requirements, so the comparisons for the valid-discharge and capacity-inaccurate bits follow each sample in order.

// File: rtl/gauge_flag_pkg.sv
package gauge_flag_pkg;
  localparam int FLAG_W    = 8;
  localparam int B_CHG     = 7;
  localparam int B_IDLE    = 6;
  localparam int B_TAPER   = 5;
  localparam int B_CAPINAC = 4;
  localparam int B_RSVD    = 3;
  localparam int B_VALDIS  = 2;
  localparam int B_EOD1    = 1;
  localparam int B_EODF    = 0;
  localparam logic [FLAG_W-1:0] FLAGS_RESET = 8'h10;

  typedef struct packed {
    logic fullClr;
    logic partClr;
    logic loadMeas;
    logic setValDis;
    logic clrValDis;
    logic capUpd;
  } flagStrobe_t;
endpackage

// File: rtl/gauge_flag_dp.sv
module gauge_flag_dp
  import gauge_flag_pkg::*;
#(
  parameter int CUR_W  = 8,
  parameter int VOLT_W = 8,
  parameter int CAP_W  = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  flagStrobe_t             strobe,
  input  logic signed [CUR_W-1:0] avgCurrent,
  input  logic [VOLT_W-1:0]       battVolt,
  input  logic [CAP_W-1:0]        remCap,
  input  logic [CAP_W-1:0]        learnedCap,
  input  logic [CUR_W-1:0]        idleThresh,
  input  logic [CUR_W-1:0]        taperThresh,
  input  logic [VOLT_W-1:0]       taperVolt,
  input  logic [VOLT_W-1:0]       edv1Volt,
  input  logic [CAP_W-1:0]        emptyCap,
  input  logic                    hostRdEn,
  output logic [FLAG_W-1:0]       flags,
  output logic [FLAG_W-1:0]       hostRdData,
  output logic                    eod1Next
);
  localparam int MAG_W = CUR_W + 1;
  localparam int FRAC_SHIFT = 4;

  logic signed [MAG_W-1:0] curExt;
  logic [MAG_W-1:0]        curMag;
  logic                    charging;
  logic                    idleNext;
  logic                    taperNext;
  logic                    eodfNext;
  logic [CAP_W-1:0]        lowCapLimit;

  always_comb begin
    curExt      = {avgCurrent[CUR_W-1], avgCurrent};
    curMag      = curExt[MAG_W-1] ? $unsigned(-curExt) : $unsigned(curExt);
    charging    = !avgCurrent[CUR_W-1] && (avgCurrent != '0);
    idleNext    = curMag < {1'b0, idleThresh};
    taperNext   = charging && ($unsigned(avgCurrent) < taperThresh) && (battVolt >= taperVolt);
    lowCapLimit = learnedCap >> FRAC_SHIFT;
    eod1Next    = !charging && (battVolt <= edv1Volt) && (remCap <= lowCapLimit);
    eodfNext    = !charging && (remCap <= emptyCap);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags <= FLAGS_RESET;
    end else if (strobe.fullClr) begin
      flags <= FLAGS_RESET;
    end else if (strobe.partClr) begin
      flags <= flags & FLAGS_RESET;
    end else begin
      if (strobe.loadMeas) begin
        flags[B_CHG]   <= charging;
        flags[B_IDLE]  <= idleNext;
        flags[B_TAPER] <= taperNext;
        flags[B_EOD1]  <= eod1Next;
        flags[B_EODF]  <= eodfNext;
      end
      if (strobe.setValDis) flags[B_VALDIS] <= 1'b1;
      if (strobe.clrValDis) flags[B_VALDIS] <= 1'b0;
      if (strobe.capUpd)    flags[B_CAPINAC] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hostRdData <= '0;
    else if (hostRdEn) hostRdData <= flags;
  end
endmodule

// File: rtl/gauge_flag_ctrl.sv
module gauge_flag_ctrl
  import gauge_flag_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sampleValid,
  input  logic        qualifyStrobe,
  input  logic        disqualifyStrobe,
  input  logic        fullResetReq,
  input  logic        partialResetReq,
  input  logic        eod1Next,
  input  logic        eod1Now,
  input  logic        valDisNow,
  output flagStrobe_t strobe,
  output logic        capUpdate
);
  logic anyReset;

  always_comb begin
    anyReset         = fullResetReq || partialResetReq;
    strobe.fullClr   = fullResetReq;
    strobe.partClr   = partialResetReq && !fullResetReq;
    strobe.loadMeas  = sampleValid && !anyReset;
    strobe.capUpd    = strobe.loadMeas && eod1Next && !eod1Now && valDisNow;
    strobe.setValDis = qualifyStrobe && !anyReset;
    strobe.clrValDis = (disqualifyStrobe || strobe.capUpd) && !anyReset;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) capUpdate <= 1'b0;
    else capUpdate <= strobe.capUpd;
  end
endmodule

// File: rtl/gauge_flag_reg.sv
module gauge_flag_reg
  import gauge_flag_pkg::*;
#(
  parameter int CUR_W  = 8,
  parameter int VOLT_W = 8,
  parameter int CAP_W  = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sampleValid,
  input  logic signed [CUR_W-1:0] avgCurrent,
  input  logic [VOLT_W-1:0]       battVolt,
  input  logic [CAP_W-1:0]        remCap,
  input  logic [CAP_W-1:0]        learnedCap,
  input  logic [CUR_W-1:0]        idleThresh,
  input  logic [CUR_W-1:0]        taperThresh,
  input  logic [VOLT_W-1:0]       taperVolt,
  input  logic [VOLT_W-1:0]       edv1Volt,
  input  logic [CAP_W-1:0]        emptyCap,
  input  logic                    qualifyStrobe,
  input  logic                    disqualifyStrobe,
  input  logic                    fullResetReq,
  input  logic                    partialResetReq,
  input  logic                    hostRdEn,
  input  logic                    hostWrEn,
  input  logic [7:0]              hostWrData,
  output logic [7:0]              statusFlags,
  output logic [7:0]              hostRdData,
  output logic                    capUpdate
);
  flagStrobe_t strobe;
  logic        eod1Next;

  gauge_flag_ctrl ctrl_i (
    .clk              (clk),
    .rst_n            (rst_n),
    .sampleValid      (sampleValid),
    .qualifyStrobe    (qualifyStrobe),
    .disqualifyStrobe (disqualifyStrobe),
    .fullResetReq     (fullResetReq),
    .partialResetReq  (partialResetReq),
    .eod1Next         (eod1Next),
    .eod1Now          (statusFlags[B_EOD1]),
    .valDisNow        (statusFlags[B_VALDIS]),
    .strobe           (strobe),
    .capUpdate        (capUpdate)
  );

  gauge_flag_dp #(.CUR_W(CUR_W), .VOLT_W(VOLT_W), .CAP_W(CAP_W)) dp_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .strobe      (strobe),
    .avgCurrent  (avgCurrent),
    .battVolt    (battVolt),
    .remCap      (remCap),
    .learnedCap  (learnedCap),
    .idleThresh  (idleThresh),
    .taperThresh (taperThresh),
    .taperVolt   (taperVolt),
    .edv1Volt    (edv1Volt),
    .emptyCap    (emptyCap),
    .hostRdEn    (hostRdEn),
    .flags       (statusFlags),
    .hostRdData  (hostRdData),
    .eod1Next    (eod1Next)
  );
endmodule

// File: rtl/gauge_flag_checker.sv
module gauge_flag_checker #(
  parameter int CUR_W = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    sampleValid,
  input logic signed [CUR_W-1:0] avgCurrent,
  input logic                    qualifyStrobe,
  input logic                    disqualifyStrobe,
  input logic                    fullResetReq,
  input logic                    partialResetReq,
  input logic                    hostWrEn,
  input logic [7:0]              hostWrData,
  input logic [7:0]              statusFlags,
  input logic                    capUpdate
);
  assert_full_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    fullResetReq |=> statusFlags == 8'h10);

  assert_partial_keeps_ci_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (partialResetReq && !fullResetReq) |=> (statusFlags[7:5] == 3'b000 && statusFlags[2:0] == 3'b000
      && statusFlags[4] == $past(statusFlags[4])));

  assert_charge_clears_eod_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sampleValid && !fullResetReq && !partialResetReq && avgCurrent > 0) |=> statusFlags[1:0] == 2'b00);

  assert_hold_meas_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!sampleValid && !fullResetReq && !partialResetReq)
      |=> ($stable(statusFlags[7:5]) && $stable(statusFlags[1:0])));

  assert_disqualify_R9: assert property (@(posedge clk) disable iff (!rst_n)
    disqualifyStrobe |=> !statusFlags[2]);

  assert_pulse_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    capUpdate |=> !capUpdate);

  assert_pulse_state_R10: assert property (@(posedge clk) disable iff (!rst_n)
    capUpdate |-> (statusFlags[1] && !statusFlags[2] && !statusFlags[4]));

  assert_ci_fall_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(statusFlags[4]) |-> capUpdate);

  assert_reserved_R12: assert property (@(posedge clk) disable iff (!rst_n)
    statusFlags[3] == 1'b0);

  assert_write_ignored_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (hostWrEn && hostWrData != statusFlags && !sampleValid && !qualifyStrobe && !disqualifyStrobe
      && !fullResetReq && !partialResetReq) |=> $stable(statusFlags));
endmodule

bind gauge_flag_reg gauge_flag_checker #(.CUR_W(CUR_W)) checker_i (
  .clk              (clk),
  .rst_n            (rst_n),
  .sampleValid      (sampleValid),
  .avgCurrent       (avgCurrent),
  .qualifyStrobe    (qualifyStrobe),
  .disqualifyStrobe (disqualifyStrobe),
  .fullResetReq     (fullResetReq),
  .partialResetReq  (partialResetReq),
  .hostWrEn         (hostWrEn),
  .hostWrData       (hostWrData),
  .statusFlags      (statusFlags),
  .capUpdate        (capUpdate)
);

// File: tb/gauge_flag_reg_tb_top.sv
module gauge_flag_reg_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sampleValid = 1'b0;
  logic signed [7:0] avgCurrent = '0;
  logic [7:0] battVolt = '0, remCap = '0, learnedCap = 8'd160;
  logic [7:0] idleThresh = 8'd5, taperThresh = 8'd20, taperVolt = 8'd180;
  logic [7:0] edv1Volt = 8'd50, emptyCap = 8'd2;
  logic qualifyStrobe = 1'b0, disqualifyStrobe = 1'b0;
  logic fullResetReq = 1'b0, partialResetReq = 1'b0;
  logic hostRdEn = 1'b0, hostWrEn = 1'b0;
  logic [7:0] hostWrData = '0;
  logic [7:0] statusFlags, hostRdData;
  logic capUpdate;

  int nChecks = 0;
  int nFails = 0;

  bit mChg, mIdle, mTaper, mCi, mVd, mE1, mEf, mUpd;

  always #2 clk = ~clk;

  gauge_flag_reg dut_i (
    .clk(clk), .rst_n(rst_n), .sampleValid(sampleValid), .avgCurrent(avgCurrent),
    .battVolt(battVolt), .remCap(remCap), .learnedCap(learnedCap), .idleThresh(idleThresh),
    .taperThresh(taperThresh), .taperVolt(taperVolt), .edv1Volt(edv1Volt), .emptyCap(emptyCap),
    .qualifyStrobe(qualifyStrobe), .disqualifyStrobe(disqualifyStrobe),
    .fullResetReq(fullResetReq), .partialResetReq(partialResetReq),
    .hostRdEn(hostRdEn), .hostWrEn(hostWrEn), .hostWrData(hostWrData),
    .statusFlags(statusFlags), .hostRdData(hostRdData), .capUpdate(capUpdate)
  );

  function automatic logic [7:0] expByte();
    return {mChg, mIdle, mTaper, mCi, 1'b0, mVd, mE1, mEf};
  endfunction

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic checkVal(int got, int exp, string tag, string what);
    nChecks++;
    if (got != exp) begin
      nFails++;
      $display("FAIL %s %s: got 0x%0h expected 0x%0h at %0t", tag, what, got, exp, $time);
    end
  endtask

  task automatic checkAll();
    string tags[8] = '{"R3", "R4", "R5", "R11", "R12", "R9", "R6", "R7"};
    logic [7:0] e = expByte();
    for (int b = 7; b >= 0; b--)
      checkVal(int'(statusFlags[b]), int'(e[b]), tags[7 - b], $sformatf("flag bit %0d", b));
    checkVal(int'(capUpdate), int'(mUpd), "R10", "capUpdate");
  endtask

  task automatic sampleStep(int cur, int volt, int rem);
    bit chg, e1;
    int mag;
    avgCurrent = 8'(cur); battVolt = 8'(volt); remCap = 8'(rem); sampleValid = 1'b1;
    chg = cur > 0;
    mag = (cur < 0) ? -cur : cur;
    e1 = !chg && volt <= int'(edv1Volt) && rem <= (int'(learnedCap) / 16);
    mUpd = e1 && !mE1 && mVd;
    if (mUpd) begin mVd = 1'b0; mCi = 1'b0; end
    mChg = chg;
    mIdle = mag < int'(idleThresh);
    mTaper = chg && cur < int'(taperThresh) && volt >= int'(taperVolt);
    mE1 = e1;
    mEf = !chg && rem <= int'(emptyCap);
    tick();
    sampleValid = 1'b0;
    checkAll();
    mUpd = 1'b0;
  endtask

  initial begin
    #(4 * 200000);
    nChecks++; nFails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    mCi = 1'b1;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    // R1: state after reset
    checkVal(int'(statusFlags), 8'h10, "R1", "flags after reset");
    checkVal(int'(hostRdData), 0, "R13", "read data after reset");
    checkAll();

    // R3 R4 R5: full current sweep, taper voltage satisfied
    for (int c = -128; c < 128; c++) sampleStep(c, 200, 200);
    // voltage sweeps for taper and end-of-discharge-1, charging and discharging
    for (int v = 0; v < 256; v++) sampleStep(10, v, 5);
    for (int v = 0; v < 256; v++) sampleStep(-10, v, 5);
    // R6 R7: capacity sweeps across several learned capacities
    for (int k = 0; k < 4; k++) begin
      learnedCap = (k == 0) ? 8'd0 : (k == 1) ? 8'd16 : (k == 2) ? 8'd160 : 8'd255;
      for (int r = 0; r < 256; r++) sampleStep(-3, 40, r);
    end
    learnedCap = 8'd160;

    // R8: inputs change without sampleValid
    sampleStep(-3, 40, 1);
    avgCurrent = 8'sd100; battVolt = 8'd255; remCap = 8'd255;
    tick();
    checkVal(int'(statusFlags), int'(expByte()), "R8", "hold without sample");
    checkAll();

    // R11: end-of-discharge-1 rise with valid-discharge clear leaves capacity-inaccurate set
    sampleStep(30, 200, 200);
    sampleStep(-3, 40, 1);

    // R9: qualify, disqualify, both at once
    qualifyStrobe = 1'b1; tick(); qualifyStrobe = 1'b0; mVd = 1'b1;
    checkAll();
    disqualifyStrobe = 1'b1; tick(); disqualifyStrobe = 1'b0; mVd = 1'b0;
    checkAll();
    qualifyStrobe = 1'b1; disqualifyStrobe = 1'b1; tick();
    qualifyStrobe = 1'b0; disqualifyStrobe = 1'b0;
    checkVal(int'(statusFlags[2]), 0, "R9", "disqualify wins");
    checkVal(int'(statusFlags[4]), 1, "R11", "capacity-inaccurate kept after disqualify");

    // R10: learning cycle completes
    sampleStep(30, 200, 200);
    qualifyStrobe = 1'b1; tick(); qualifyStrobe = 1'b0; mVd = 1'b1;
    checkAll();
    sampleStep(-3, 40, 1);
    checkVal(int'(capUpdate), 1, "R10", "update pulse");
    tick();
    checkVal(int'(capUpdate), 0, "R10", "pulse one cycle");
    checkAll();
    // level stays at 1: no second pulse
    qualifyStrobe = 1'b1; tick(); qualifyStrobe = 1'b0; mVd = 1'b1;
    sampleStep(-3, 40, 1);
    checkVal(int'(capUpdate), 0, "R10", "no pulse without rise");

    // R2: partial reset keeps bit 4 at 0
    partialResetReq = 1'b1; tick(); partialResetReq = 1'b0;
    mChg = 0; mIdle = 0; mTaper = 0; mVd = 0; mE1 = 0; mEf = 0;
    checkVal(int'(statusFlags), 8'h00, "R2", "partial reset, bit 4 clear");
    // R1: full reset request
    sampleStep(-3, 40, 1);
    fullResetReq = 1'b1; tick(); fullResetReq = 1'b0;
    mChg = 0; mIdle = 0; mTaper = 0; mVd = 0; mE1 = 0; mEf = 0; mCi = 1;
    checkVal(int'(statusFlags), 8'h10, "R1", "full reset request");
    // R2: partial reset keeps bit 4 at 1
    sampleStep(-3, 40, 1);
    qualifyStrobe = 1'b1; tick(); qualifyStrobe = 1'b0;
    partialResetReq = 1'b1; tick(); partialResetReq = 1'b0;
    mChg = 0; mIdle = 0; mTaper = 0; mVd = 0; mE1 = 0; mEf = 0;
    checkVal(int'(statusFlags), 8'h10, "R2", "partial reset, bit 4 set");

    // R13: host read and ignored writes
    sampleStep(15, 200, 200);
    hostRdEn = 1'b1; tick(); hostRdEn = 1'b0;
    checkVal(int'(hostRdData), int'(expByte()), "R13", "read data");
    for (int w = 0; w < 256; w += 17) begin
      hostWrEn = 1'b1; hostWrData = 8'(w); tick();
      checkVal(int'(statusFlags), int'(expByte()), "R13", "write ignored");
    end
    hostWrEn = 1'b0;
    hostRdEn = 1'b1; tick(); hostRdEn = 1'b0;
    checkVal(int'(hostRdData), int'(expByte()), "R13", "read after writes");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule